// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block manages three 8-bit general-purpose I/O ports behind a simple synchronous register bus. Each pin takes one of eight modes, chosen by one bit from each of three per-port registers: a direction register and two configuration registers. The modes cover input, output and interrupt use, with pull-up and driver options. The block drives per-pin output value, output-enable, open-drain, pull-up and weak pull-up controls toward the pad ring. It takes the raw pad levels back and passes them through a two-flop synchronizer.

Software writes the two configuration registers first. These writes land in staging copies and have no effect yet. Writing the port's direction register then applies all three bit-planes to that port in one step, so a pin never passes through a mode that software did not intend. A read of a port data address returns a per-pin mix: output-mode pins give back the output buffer, and every other pin gives its synchronized pad level. On the first two ports, the interrupt-mode pins are ORed into one level per port. An edge of the selected polarity on that level sets a sticky pending flag, which drives that port's interrupt request until software clears it.

Top module: `gpio_bank`

Address map (AW = 4): 0..2 port data A/B/C; 3..5 staged cfg0 A/B/C; 6..8 staged cfg1 A/B/C; 9..11 direction A/B/C (applies staging); 12 polarity (bit p for port p, 1 = rising, 0 = falling, reset 0); 13 pending status (bit p, write 1 to clear); 14 and 15 unused.

## Requirements
- R1: After reset every pin is input high-Z: pad_oe, pad_od, pad_pu, pad_wpu, pad_out and irq_req are all zero.
- R2: Writes to cfg0/cfg1 (addresses 3..8) change no pad control until the matching direction register (9..11) is written; that write applies direction, cfg1 and cfg0 for the whole port in the same cycle.
- R3: Pin mode is {dir,cfg1,cfg0}. 000 input high-Z; 001 input pull-up; 010 interrupt with pull-up; 011 interrupt without pull-up; 100 output push-pull; 101 output with pull-up; 110 output with weak pull-up; 111 open-drain. pad_pu is set for 001, 010 and 101, and pad_wpu is set for 110.
- R4: In mode 111, pad_od is 1. The pin drives only 0: pad_oe equals the inverse of the buffer bit, and pad_out is 0.
- R5: Writing a port data address updates its output buffer. Pins in modes 100, 101 and 110 drive it with pad_oe=1, while input and interrupt pins keep pad_oe=0.
- R6: A data read returns the buffer bit for output-mode pins and the synchronized pad level for other pins. That level is visible two clock edges after the pad changes.
- R7: On port C, modes 010 and 011 act as inputs (010 keeps its pull-up) and never set a pending flag.
- R8: On ports A and B, the OR of the interrupt-mode pins is edge-detected with the polarity bit (1 rising, 0 falling). A matching edge sets pending, and irq_req[p] follows pending, on the third clock edge after the pad change.
- R9: Writing 1 to a bit of the status register (13) clears that port's pending flag; writing 0 leaves it set. The status register reads back the pending flags.
- R10: Writes to addresses 14 and 15 change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 24 | Raw pad levels, port p in bits [8p+7:8p] |
| pad_out | output | 24 | Value driven when enabled |
| pad_oe | output | 24 | Output enable |
| pad_od | output | 24 | Open-drain mode flag |
| pad_pu | output | 24 | Pull-up enable |
| pad_wpu | output | 24 | Weak pull-up enable |
| irq_req | output | 2 | Interrupt request for ports A and B |

## Verification
Register writes take effect on the clock edge that accepts them, so pad controls and buffer read-back are checked at the falling edge that follows the write. A pad change is seen in read data two rising edges later, and it raises irq_req on the third rising edge. The bench checks the interrupt line one falling edge at a time, so it confirms both that the request is still low after the second edge and that it is high after the third. A pending clear is checked one edge after the status write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        M_IN_Z    = 3'b000,
        M_IN_PU   = 3'b001,
        M_IRQ_PU  = 3'b010,
        M_IRQ_NP  = 3'b011,
        M_OUT_PP  = 3'b100,
        M_OUT_PU  = 3'b101,
        M_OUT_WPU = 3'b110,
        M_OUT_OD  = 3'b111
    } pin_mode_e;

    typedef struct packed {
        logic is_out;   // read returns buffer
        logic drv;      // always drives when output
        logic od;       // open drain
        logic pu;
        logic wpu;
        logic irq;
    } pin_ctl_t;

    function automatic pin_ctl_t mode_ctl(input pin_mode_e m);
        pin_ctl_t c;
        c = '0;
        unique case (m)
            M_IN_Z:    c = '0;
            M_IN_PU:   c.pu = 1'b1;
            M_IRQ_PU:  begin c.pu = 1'b1; c.irq = 1'b1; end
            M_IRQ_NP:  c.irq = 1'b1;
            M_OUT_PP:  begin c.is_out = 1'b1; c.drv = 1'b1; end
            M_OUT_PU:  begin c.is_out = 1'b1; c.drv = 1'b1; c.pu = 1'b1; end
            M_OUT_WPU: begin c.is_out = 1'b1; c.drv = 1'b1; c.wpu = 1'b1; end
            M_OUT_OD:  begin c.is_out = 1'b1; c.od = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.s2;
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PW     = 8,
    parameter bit          IRQ_OK = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sh0,
    input  logic          wr_sh1,
    input  logic          wr_dir,
    input  logic          wr_buf,
    input  logic [PW-1:0] wdata,
    input  logic [PW-1:0] pin_lvl,
    output logic [PW-1:0] pin_drv,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] pin_od,
    output logic [PW-1:0] pin_pu,
    output logic [PW-1:0] pin_wpu,
    output logic [PW-1:0] rd_val,
    output logic          irq_lvl
);
    typedef struct packed {
        logic [PW-1:0] sh0;
        logic [PW-1:0] sh1;
        logic [PW-1:0] dir;
        logic [PW-1:0] act1;
        logic [PW-1:0] act0;
        logic [PW-1:0] obuf;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [PW-1:0] irq_mask;

    always_comb begin
        st_d = st_q;
        if (wr_sh0) st_d.sh0 = wdata;
        if (wr_sh1) st_d.sh1 = wdata;
        if (wr_dir) begin
            st_d.dir  = wdata;
            st_d.act1 = st_q.sh1;
            st_d.act0 = st_q.sh0;
        end
        if (wr_buf) st_d.obuf = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            pin_ctl_t c;
            c = mode_ctl(pin_mode_e'({st_q.dir[i], st_q.act1[i], st_q.act0[i]}));
            pin_drv[i]  = st_q.obuf[i] & ~c.od;
            pin_oe[i]   = c.drv | (c.od & ~st_q.obuf[i]);
            pin_od[i]   = c.od;
            pin_pu[i]   = c.pu;
            pin_wpu[i]  = c.wpu;
            rd_val[i]   = c.is_out ? st_q.obuf[i] : pin_lvl[i];
            irq_mask[i] = c.irq & IRQ_OK;
        end
    end

    assign irq_lvl = |(pin_lvl & irq_mask);

    // Active configuration moves only on a direction write (R2)
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable({st_q.dir, st_q.act1, st_q.act0}));

    // Open-drain pins never drive a high level (R4)
    p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_od & pin_oe & pin_drv) == '0);
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic clr,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } irq_t;

    irq_t st_d, st_q;
    logic hit;

    always_comb begin
        hit       = rise_sel ? (lvl & ~st_q.prev) : (~lvl & st_q.prev);
        st_d.prev = lvl;
        st_d.pend = hit | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

    p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !pending);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int unsigned NPORTS = 3,
    parameter int unsigned PW     = 8,
    parameter int unsigned NIRQ   = 2,
    parameter int unsigned AW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [PW-1:0]        bus_wdata,
    output logic [PW-1:0]        bus_rdata,
    input  logic [NPORTS*PW-1:0] pad_in,
    output logic [NPORTS*PW-1:0] pad_out,
    output logic [NPORTS*PW-1:0] pad_oe,
    output logic [NPORTS*PW-1:0] pad_od,
    output logic [NPORTS*PW-1:0] pad_pu,
    output logic [NPORTS*PW-1:0] pad_wpu,
    output logic [NIRQ-1:0]      irq_req
);
    localparam int unsigned CFG0_BASE = NPORTS;
    localparam int unsigned CFG1_BASE = 2 * NPORTS;
    localparam int unsigned DIR_BASE  = 3 * NPORTS;
    localparam int unsigned POL_ADDR  = 4 * NPORTS;
    localparam int unsigned STAT_ADDR = 4 * NPORTS + 1;

    typedef struct packed {
        logic [NPORTS-1:0] pol;
    } top_t;

    top_t st_d, st_q;
    logic [NPORTS*PW-1:0] lvl;
    logic [PW-1:0]        rd_val [NPORTS];
    logic [NPORTS-1:0]    irq_lvl;
    logic [NPORTS-1:0]    pend;

    gpio_sync #(.N(NPORTS*PW)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(lvl)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpio_port_cfg #(.PW(PW), .IRQ_OK(p < NIRQ)) u_cfg (
            .clk(clk), .rst_n(rst_n),
            .wr_sh0(bus_we && bus_addr == AW'(CFG0_BASE + p)),
            .wr_sh1(bus_we && bus_addr == AW'(CFG1_BASE + p)),
            .wr_dir(bus_we && bus_addr == AW'(DIR_BASE + p)),
            .wr_buf(bus_we && bus_addr == AW'(p)),
            .wdata(bus_wdata),
            .pin_lvl(lvl[p*PW +: PW]),
            .pin_drv(pad_out[p*PW +: PW]),
            .pin_oe(pad_oe[p*PW +: PW]),
            .pin_od(pad_od[p*PW +: PW]),
            .pin_pu(pad_pu[p*PW +: PW]),
            .pin_wpu(pad_wpu[p*PW +: PW]),
            .rd_val(rd_val[p]),
            .irq_lvl(irq_lvl[p])
        );

        gpio_irq_edge u_irq (
            .clk(clk), .rst_n(rst_n),
            .lvl(irq_lvl[p]),
            .rise_sel(st_q.pol[p]),
            .clr(bus_we && bus_addr == AW'(STAT_ADDR) && bus_wdata[p]),
            .pending(pend[p])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_we && bus_addr == AW'(POL_ADDR)) st_d.pol = bus_wdata[NPORTS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++)
            if (bus_addr == AW'(p)) bus_rdata = rd_val[p];
        if (bus_addr == AW'(POL_ADDR))  bus_rdata[NPORTS-1:0] = st_q.pol;
        if (bus_addr == AW'(STAT_ADDR)) bus_rdata[NPORTS-1:0] = pend;
    end

    assign irq_req = pend[NIRQ-1:0];

    // Unused addresses read back as zero (R10)
    p_bad_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > AW'(STAT_ADDR)) |-> bus_rdata == '0);

    // Port C never raises a pending flag (R7)
    p_portc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend[NPORTS-1] == 1'b0);
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_out, pad_oe, pad_od, pad_pu, pad_wpu;
    logic [1:0]  irq_req;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_wpu(pad_wpu), .irq_req(irq_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "oe", pad_oe, 0);
        chk("R1", "od", pad_od, 0);
        chk("R1", "pu", pad_pu, 0);
        chk("R1", "wpu", pad_wpu, 0);
        chk("R1", "out", pad_out, 0);
        chk("R1", "irq", irq_req, 0);
        rd(4'd0, v);
        chk("R1", "read A", v, 8'h00);
    endtask

    task automatic t_staging();
        wr(4'd3, 8'hFF);          // cfg0 A
        wr(4'd6, 8'h00);          // cfg1 A
        chk("R2", "pu before dir write", pad_pu[7:0], 8'h00);
        wr(4'd9, 8'h00);          // dir A applies 001
        chk("R2", "pu after dir write", pad_pu[7:0], 8'hFF);
        chk("R3", "mode 001 oe", pad_oe[7:0], 8'h00);
    endtask

    task automatic t_modes();
        // port B pin i gets mode i
        wr(4'd4, 8'hAA);
        wr(4'd7, 8'hCC);
        wr(4'd10, 8'hF0);
        chk("R3", "pu modes 001/010/101", pad_pu[15:8], 8'h26);
        chk("R3", "wpu mode 110", pad_wpu[15:8], 8'h40);
        chk("R4", "od mode 111", pad_od[15:8], 8'h80);
        chk("R4", "oe with buffer 0", pad_oe[15:8], 8'hF0);
        wr(4'd1, 8'hFF);
        chk("R5", "oe with buffer 1", pad_oe[15:8], 8'h70);
        chk("R4", "out with buffer 1", pad_out[15:8], 8'h7F);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        pad_in[15:8] = 8'h05;
        @(negedge clk);
        @(negedge clk);
        rd(4'd1, v);
        chk("R6", "mixed read", v, 8'hF5);
        wr(4'd1, 8'h30);
        rd(4'd1, v);
        chk("R6", "mixed read new buffer", v, 8'h35);
        chk("R5", "input pins not driven", pad_oe[11:8], 4'h0);
    endtask

    task automatic t_portc();
        logic [7:0] v;
        wr(4'd5, 8'h00);
        wr(4'd8, 8'hFF);
        wr(4'd11, 8'h00);         // port C all mode 010
        chk("R7", "pu on C", pad_pu[23:16], 8'hFF);
        pad_in[23:16] = 8'hFF;
        repeat (3) @(negedge clk);
        rd(4'd2, v);
        chk("R7", "read C", v, 8'hFF);
        pad_in[23:16] = 8'h00;
        repeat (3) @(negedge clk);
        rd(4'd13, v);
        chk("R7", "no pending on C", v, 8'h00);
        chk("R7", "irq lines", irq_req, 2'b00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(4'd3, 8'hFF);
        wr(4'd6, 8'hFF);
        wr(4'd9, 8'h00);          // port A all mode 011
        wr(4'd12, 8'h01);         // A rising
        pad_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "irq not before third edge", irq_req[0], 1'b0);
        @(negedge clk);
        chk("R8", "irq on third edge", irq_req[0], 1'b1);
        rd(4'd13, v);
        chk("R9", "status read", v, 8'h01);
        wr(4'd13, 8'h00);
        chk("R9", "write 0 keeps pending", irq_req[0], 1'b1);
        wr(4'd13, 8'h01);
        chk("R9", "write 1 clears", irq_req[0], 1'b0);
        wr(4'd12, 8'h00);         // A falling
        pad_in[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "falling not yet", irq_req[0], 1'b0);
        @(negedge clk);
        chk("R8", "falling edge", irq_req[0], 1'b1);
        wr(4'd13, 8'h01);
        chk("R9", "cleared again", irq_req[0], 1'b0);
    endtask

    task automatic t_bad_addr();
        logic [7:0] v;
        logic [23:0] oe0, pu0;
        oe0 = pad_oe; pu0 = pad_pu;
        wr(4'd14, 8'hFF);
        wr(4'd15, 8'hFF);
        chk("R10", "oe unchanged", pad_oe, oe0);
        chk("R10", "pu unchanged", pad_pu, pu0);
        rd(4'd14, v);
        chk("R10", "read 14", v, 8'h00);
        rd(4'd15, v);
        chk("R10", "read 15", v, 8'h00);
        rd(4'd1, v);
        chk("R10", "port B buffer kept", v, 8'h35);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_staging();
        t_modes();
        t_readback();
        t_portc();
        t_irq();
        t_bad_addr();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule